// File: doc/BRIEF.md
# Double-Buffered Spectrum Accumulator

This block builds energy histograms from a stream of analyzed detector events. Each event names a pixel, one of eight time-of-flight bins and one of sixteen energy channels. For every event the block finds the matching 16-bit counter in an external byte-wide RAM and increments it with a read-modify-write sequence. The counter is stored as a low byte and a high byte, and it stops at 0xFFFF instead of wrapping.

The RAM is split into two equal halves. One half collects counts while the host reads the other. A swap request is held until no event is in progress. The swap then flips the active half and writes zero over every byte of the newly active half before the next event is admitted.

When each event is complete, the block raises a one-cycle event strobe and a one-cycle front-end reset together, and it shows the pixel number on an 8-bit output. An event that arrives while the block is working sees `ev_busy` and is held off; it is not dropped. The design targets a 3.2 MHz system clock.

Top module: `spec_accum`

## Requirements
- R1: After reset, `ev_busy`, `ev_strobe`, `fe_reset` and `mem_we` are low, and `active_buf` is 0.
- R2: A counter's byte address is {active half, pixel, tof[2:0], energy[3:0], byte}, where byte 0 holds bits 7:0 and byte 1 holds bits 15:8.
- R3: When the low byte is not 0xFF, only the low byte is rewritten as low+1, and the strobe appears in the 3rd cycle after the event is accepted.
- R4: When the low byte is 0xFF and the high byte is not, the high byte becomes high+1 and the low byte becomes 0x00, and the strobe appears in the 6th cycle after acceptance.
- R5: A counter holding 0xFFFF is left unchanged, no write is made, and the strobe appears in the 5th cycle after acceptance.
- R6: `ev_strobe` and `fe_reset` are single-cycle pulses that occur together once per event, and while they are high `pix_id` equals the event's pixel, zero-extended.
- R7: `ev_busy` is high while an update, a pending swap or a clear is in progress. An event held by `ev_valid` during that time is accepted later and counted exactly once.
- R8: A swap request raised during an update takes effect only after that update. The swap toggles `active_buf` and then zeroes all 2^(ADDR_W-1) bytes of the new half, one per cycle. `ev_busy` stays high for HALF+1 cycles, counted from the cycle after the request (or from the cycle after the strobe).
- R9: Every RAM write targets the half selected by `active_buf`, so the half being read by the host is never disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | An analyzed event is offered |
| ev_pixel | input | PIX_W | Pixel number of the event |
| ev_tof | input | 3 | Time-of-flight spectrum select |
| ev_energy | input | 4 | Energy channel |
| ev_busy | output | 1 | Event not accepted this cycle; hold it |
| swap_req | input | 1 | One-cycle request to exchange the halves |
| active_buf | output | 1 | Half currently accumulating |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_re | output | 1 | RAM read; data is returned the next cycle |
| mem_we | output | 1 | RAM write strobe |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, registered in the RAM |
| ev_strobe | output | 1 | Event-timing pulse for the host side |
| fe_reset | output | 1 | Front-end reset pulse after analysis |
| pix_id | output | 8 | Pixel number of the most recent event |

## Verification
The event is accepted at the first rising edge where `ev_valid` is high and `ev_busy` is low. The strobe is then due 3, 6 or 5 cycles later, for a plain increment, a carry and saturation respectively. The bench predicts which of the three cases applies from its own copy of the counter and measures the gap at falling edges. It reads both RAM bytes in the same cycle the strobe is seen, because the last write lands on the edge that raises the strobe. For swaps, the number of falling edges with `ev_busy` high is compared with HALF+1, and then both halves are compared against the model.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int TOF_W = 3;
  localparam int EN_W  = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_LO, S_WR_LO, S_RD_HI, S_WR_HI, S_WR_Z, S_DONE
  } rmw_state_t;

  // byte increment used by both halves of the counter
  function automatic logic [7:0] bump(input logic [7:0] b);
    return b + 8'd1;
  endfunction

  // true when a byte would carry out on increment
  function automatic logic byte_full(input logic [7:0] b);
    return b == 8'hFF;
  endfunction
endpackage

// File: rtl/sa_rmw_fsm.sv
module sa_rmw_fsm
  import sa_pkg::*;
#(
  parameter int PIX_W = 5,
  localparam int BIN_W = PIX_W + TOF_W + EN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [TOF_W-1:0] tof_in,
  input  logic [EN_W-1:0]  en_in,
  input  logic [7:0]       rd_data,
  output logic             idle,
  output logic             done,
  output logic             rd_en,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic [BIN_W-1:0] bin_off,
  output logic [PIX_W-1:0] pix_q
);
  rmw_state_t       state;
  logic [TOF_W-1:0] tof_q;
  logic [EN_W-1:0]  en_q;
  logic             hi_sel;
  logic             full;

  assign full = byte_full(rd_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      pix_q <= '0;
      tof_q <= '0;
      en_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          pix_q <= pix_in;
          tof_q <= tof_in;
          en_q  <= en_in;
          state <= S_RD_LO;
        end
        S_RD_LO: state <= S_WR_LO;
        S_WR_LO: state <= full ? S_RD_HI : S_DONE;
        S_RD_HI: state <= S_WR_HI;
        S_WR_HI: state <= full ? S_DONE : S_WR_Z;
        S_WR_Z:  state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    hi_sel  = (state == S_RD_HI) || (state == S_WR_HI);
    rd_en   = (state == S_RD_LO) || (state == S_RD_HI);
    wr_en   = ((state == S_WR_LO || state == S_WR_HI) && !full) || (state == S_WR_Z);
    wr_data = (state == S_WR_Z) ? 8'h00 : bump(rd_data);
    bin_off = {pix_q, tof_q, en_q, hi_sel};
    idle    = (state == S_IDLE);
    done    = (state == S_DONE);
  end
endmodule

// File: rtl/sa_swap_ctl.sv
module sa_swap_ctl #(
  parameter int BIN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap_req,
  input  logic             rmw_idle,
  output logic             active_buf,
  output logic             pend,
  output logic             clearing,
  output logic [BIN_W-1:0] clr_addr
);
  localparam logic [BIN_W-1:0] LAST = '1;
  logic start;

  assign start = pend && rmw_idle && !clearing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_buf <= 1'b0;
      pend       <= 1'b0;
      clearing   <= 1'b0;
      clr_addr   <= '0;
    end else begin
      if (start) begin
        pend       <= 1'b0;
        active_buf <= !active_buf;
        clearing   <= 1'b1;
        clr_addr   <= '0;
      end else if (clearing) begin
        clr_addr <= clr_addr + 1'b1;
        if (clr_addr == LAST) clearing <= 1'b0;
      end
      if (swap_req) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/sa_mem_mux.sv
module sa_mem_mux #(
  parameter int BIN_W = 13,
  localparam int ADDR_W = BIN_W + 1
) (
  input  logic              active_buf,
  input  logic              clearing,
  input  logic [BIN_W-1:0]  clr_addr,
  input  logic [BIN_W-1:0]  bin_off,
  input  logic              rmw_re,
  input  logic              rmw_we,
  input  logic [7:0]        rmw_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata
);
  function automatic logic [ADDR_W-1:0] place(input logic half, input logic [BIN_W-1:0] off);
    return {half, off};
  endfunction

  always_comb begin
    if (clearing) begin
      mem_addr  = place(active_buf, clr_addr);
      mem_re    = 1'b0;
      mem_we    = 1'b1;
      mem_wdata = 8'h00;
    end else begin
      mem_addr  = place(active_buf, bin_off);
      mem_re    = rmw_re;
      mem_we    = rmw_we;
      mem_wdata = rmw_wdata;
    end
  end
endmodule

// File: rtl/spec_accum.sv
module spec_accum
  import sa_pkg::*;
#(
  parameter int PIX_W = 5,
  localparam int BIN_W = PIX_W + TOF_W + EN_W + 1,
  localparam int ADDR_W = BIN_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [PIX_W-1:0]  ev_pixel,
  input  logic [TOF_W-1:0]  ev_tof,
  input  logic [EN_W-1:0]   ev_energy,
  output logic              ev_busy,
  input  logic              swap_req,
  output logic              active_buf,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_re,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              ev_strobe,
  output logic              fe_reset,
  output logic [7:0]        pix_id
);
  logic             rmw_idle, rmw_done, rmw_re, rmw_we;
  logic [7:0]       rmw_wdata;
  logic [BIN_W-1:0] bin_off, clr_addr;
  logic [PIX_W-1:0] pix_q;
  logic             pend, clearing, accept;

  assign ev_busy = !rmw_idle || pend || clearing;
  assign accept  = ev_valid && !ev_busy;

  sa_rmw_fsm #(.PIX_W(PIX_W)) u_rmw (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .pix_in(ev_pixel), .tof_in(ev_tof), .en_in(ev_energy),
    .rd_data(mem_rdata), .idle(rmw_idle), .done(rmw_done),
    .rd_en(rmw_re), .wr_en(rmw_we), .wr_data(rmw_wdata),
    .bin_off(bin_off), .pix_q(pix_q)
  );

  sa_swap_ctl #(.BIN_W(BIN_W)) u_swap (
    .clk(clk), .rst_n(rst_n), .swap_req(swap_req), .rmw_idle(rmw_idle),
    .active_buf(active_buf), .pend(pend), .clearing(clearing),
    .clr_addr(clr_addr)
  );

  sa_mem_mux #(.BIN_W(BIN_W)) u_mux (
    .active_buf(active_buf), .clearing(clearing), .clr_addr(clr_addr),
    .bin_off(bin_off), .rmw_re(rmw_re), .rmw_we(rmw_we),
    .rmw_wdata(rmw_wdata), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  assign ev_strobe = rmw_done;
  assign fe_reset  = rmw_done;

  always_comb begin
    pix_id = '0;
    pix_id[PIX_W-1:0] = pix_q;
  end
endmodule

// File: rtl/sa_chk.sv
module sa_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_strobe,
  input logic              fe_reset,
  input logic              ev_busy,
  input logic              mem_we,
  input logic              mem_re,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [7:0]        mem_wdata,
  input logic              active_buf,
  input logic              rmw_idle,
  input logic              clearing
);
  // R6
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe |=> !ev_strobe);
  // R6
  fe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fe_reset |-> ev_strobe);
  // R7
  busy_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_strobe |-> $past(ev_busy));
  // R9
  buf_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1] == active_buf));
  // R8
  swap_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_buf) |-> $past(rmw_idle));
  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearing |-> (mem_we && mem_wdata == 8'h00 && ev_busy));
  // R2
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
endmodule

bind spec_accum sa_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe), .fe_reset(fe_reset),
  .ev_busy(ev_busy), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .active_buf(active_buf), .rmw_idle(rmw_idle),
  .clearing(clearing)
);

// File: tb/sim_spec_accum.sv
module sim_spec_accum;
  localparam int PW   = 2;
  localparam int AW   = PW + 9;
  localparam int HALF = 1 << (AW - 1);
  localparam int NBIN = 1 << (AW - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, swap_req = 1'b0;
  logic [PW-1:0] ev_pixel = '0;
  logic [2:0] ev_tof = '0;
  logic [3:0] ev_energy = '0;
  logic ev_busy, active_buf, mem_re, mem_we, ev_strobe, fe_reset;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, pix_id;

  logic [7:0]  ram [0:2*HALF-1];
  logic [15:0] mdl [0:NBIN-1];
  int vecs = 0, errs = 0;

  always #5 clk = ~clk;

  spec_accum #(.PIX_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pixel(ev_pixel),
    .ev_tof(ev_tof), .ev_energy(ev_energy), .ev_busy(ev_busy),
    .swap_req(swap_req), .active_buf(active_buf), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .ev_strobe(ev_strobe), .fe_reset(fe_reset),
    .pix_id(pix_id)
  );

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bidx(int b, int p, int t, int e);
    return ((b * 4 + p) * 8 + t) * 16 + e;
  endfunction

  function automatic logic [15:0] stored(int idx);
    return {ram[2*idx+1], ram[2*idx]};
  endfunction

  function automatic int exp_lat(logic [15:0] c);
    if (c == 16'hFFFF) return 5;
    if (c % 256 == 255) return 6;
    return 3;
  endfunction

  function automatic logic [15:0] sat_inc(logic [15:0] c);
    return (c == 16'hFFFF) ? c : c + 16'd1;
  endfunction

  task automatic preload(int b, int p, int t, int e, logic [15:0] v);
    int idx = bidx(b, p, t, e);
    mdl[idx] = v;
    ram[2*idx]   = v[7:0];
    ram[2*idx+1] = v[15:8];
  endtask

  task automatic compare_all(input string req);
    int mis = 0;
    for (int i = 0; i < NBIN; i++) if (stored(i) != mdl[i]) mis++;
    chk(mis == 0, req, mis, 0);
  endtask

  task automatic finish_clear(input logic old_ab);
    int n = 0;
    while (ev_busy && n < 5000) begin n++; @(negedge clk); end
    chk(n == HALF + 1, "R8 busy length of clear", n, HALF + 1);
    chk(active_buf == !old_ab, "R8 active half toggled", active_buf, !old_ab);
    for (int i = 0; i < NBIN / 2; i++) mdl[(!old_ab) * (NBIN / 2) + i] = 16'h0;
    compare_all("R8 R9 halves after swap");
  endtask

  task automatic send(int p, int t, int e, bit swap_mid);
    logic ab;
    int idx, lat;
    logic [15:0] cur;
    string tg;
    ab  = active_buf;
    idx = bidx(ab, p, t, e);
    cur = mdl[idx];
    tg  = (cur == 16'hFFFF) ? "R5" : ((cur % 256 == 255) ? "R4" : "R3");
    @(negedge clk);
    ev_valid = 1'b1; ev_pixel = PW'(p); ev_tof = 3'(t); ev_energy = 4'(e);
    while (ev_busy) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    lat = 1;
    chk(ev_busy, "R7 busy while updating", ev_busy, 1);
    if (swap_mid) swap_req = 1'b1;
    while (!ev_strobe && lat < 12) begin
      @(negedge clk);
      swap_req = 1'b0;
      lat++;
    end
    chk(lat == exp_lat(cur), {tg, " strobe latency"}, lat, exp_lat(cur));
    chk(pix_id == 8'(p) && fe_reset, "R6 pix_id and fe_reset", pix_id, p);
    mdl[idx] = sat_inc(cur);
    chk(stored(idx) == mdl[idx], {tg, " stored count"}, stored(idx), mdl[idx]);
    @(negedge clk);
    chk(!ev_strobe, "R6 strobe one cycle", ev_strobe, 0);
    if (swap_mid) begin
      chk(active_buf == ab, "R8 swap deferred past update", active_buf, ab);
      finish_clear(ab);
    end
  endtask

  task automatic swap();
    logic ab = active_buf;
    @(negedge clk); swap_req = 1'b1;
    @(negedge clk); swap_req = 1'b0;
    finish_clear(ab);
  endtask

  task automatic random_events(int n);
    for (int k = 0; k < n; k++) begin
      int p = int'($urandom % 4), t = int'($urandom % 3), e = int'($urandom % 5);
      if ($urandom % 10 == 0)
        preload(active_buf, p, t, e, {8'($urandom), 8'hFF});
      send(p, t, e, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; vecs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 2 * HALF; i++) ram[i] = (i < HALF) ? 8'h00 : 8'($urandom);
    for (int i = 0; i < NBIN; i++) mdl[i] = stored(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!ev_busy && !ev_strobe && !fe_reset, "R1 idle outputs", {ev_busy, ev_strobe, fe_reset}, 0);
    chk(!active_buf && !mem_we, "R1 half and write", {active_buf, mem_we}, 0);

    // directed corners
    send(3, 5, 9, 1'b0);                  // R3 fresh bin, R2 placement
    preload(0, 1, 2, 3, 16'h00FF); send(1, 2, 3, 1'b0);   // R4
    preload(0, 0, 0, 0, 16'h12FF); send(0, 0, 0, 1'b0);   // R4
    preload(0, 2, 7, 15, 16'hFFFE); send(2, 7, 15, 1'b0); // R3 to max
    send(2, 7, 15, 1'b0);                                 // R5
    send(2, 7, 15, 1'b0);                                 // R5 again
    compare_all("R2 R9 map after directed");

    random_events(120);
    compare_all("R2 R9 map after random");
    swap();                                // R8 idle swap
    random_events(60);
    send(1, 1, 1, 1'b1);                   // R8 swap during update
    random_events(40);
    compare_all("R2 R7 R9 final compare");

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule